// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an asynchronous static RAM of 512K bytes. The host offers one read or one write at a time over a valid/ready handshake: a 19-bit location, a direction flag and, for writes, a byte. The controller turns each request into a timed sequence on the active-low chip-select, output-gate and write-strobe lines. It holds the address still whenever the RAM is selected. It drives the shared data lines only when the RAM cannot be driving them. For reads it returns the fetched byte with a one-cycle valid pulse.

Every timing limit is a parameter counted in whole clock cycles. It is set by dividing the nanosecond figure by the clock period and rounding up, with at least one cycle for any nonzero limit. The parameters are: address setup before selection, read access window, write-strobe width, data setup before the strobe rises, bus turnaround and recovery between accesses. Writes keep the output gate high for their whole length, so the RAM never drives the bus while the controller does. The chip-select and write strobe fall on the same clock edge, so the RAM outputs stay in high impedance for that access.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever idle, mem_ce_n, mem_oe_n and mem_we_n are all 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: mem_addr changes only in cycles where mem_ce_n is 1, and it holds its value for as long as mem_ce_n stays 0.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly READ_CYC consecutive cycles. rsp_valid is 1 for exactly one cycle. That cycle is SETUP_CYC+READ_CYC+1 cycles after the cycle in which the request was accepted, and it carries the byte stored at the requested location.
- R4: A write drops mem_ce_n and mem_we_n on the same edge and holds both at 0 for exactly WPULSE_CYC cycles, with mem_oe_n at 1 throughout. Afterwards the location holds req_wdata.
- R5: During a write, mem_dq_oe is 1 for at least the last DSETUP_CYC cycles of the strobe pulse and for the cycle after mem_we_n rises. mem_dq_out holds the write byte during those cycles.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0. It rises only after mem_oe_n has been 1 for more than TURN_CYC consecutive cycles.
- R7: req_ready is 1 only while idle. It returns to 1 in the cycle SETUP_CYC+READ_CYC+RECOV_CYC+1 cycles after a read is accepted, and SETUP_CYC+WPULSE_CYC+RECOV_CYC+1 cycles after a write is accepted.
- R8: Changes on req_addr, req_wdata and req_write while req_ready is 0 do not alter the access in flight.
- R9: Every location from 0 to 524287 is reachable, including both ends of the range.
- R10: A write never produces an rsp_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller is idle and takes the request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 19 | Target location |
| req_wdata | input | 8 | Byte to store |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | 8 | Returned read byte |
| mem_addr | output | 19 | RAM address lines |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Byte the controller drives onto the data lines |
| mem_dq_oe | output | 1 | Enable for the controller's data-line driver |
| mem_dq_in | input | 8 | Byte sampled from the data lines |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the timing parameters are at least one cycle and that DSETUP_CYC does not exceed WPULSE_CYC. Under those conditions, the strobe ordering, address stability and driver rules follow from the controller alone, whatever the host does. The bench drives every request on the falling edge and waits for req_ready before offering the next one. It disturbs the request inputs only while req_valid is low. A behavioural RAM model answers reads only while selected and gated, and it stores a byte when the write strobe rises. It also reports any strobe order, pulse width, address movement or driver conflict it sees.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_RECOV
    } ctrl_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter for one strobe phase; last is high in the final cycle.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_tracker.sv
// Counts consecutive cycles with the output gate high; saturates.
module sram_turn_tracker #(
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic turn_ok
);
    localparam int TW = $clog2(TURN_CYC + 1) + 1;
    localparam logic [TW-1:0] SAT = TW'(TURN_CYC);

    logic [TW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!oe_n) begin
            run_d = '0;
        end else if (run_q != SAT) begin
            run_d = run_q + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    // completed high cycles plus the current one reach the limit
    assign turn_ok = oe_n && ((run_q + TW'(1)) >= SAT);
endmodule

// File: rtl/sram_rd_capture.sv
// Registers the data lines on the last access cycle and pulses valid.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              vld_d, vld_q;

    always_comb begin
        vld_d  = cap_en;
        data_d = cap_en ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            data_q <= data_d;
            vld_q  <= vld_d;
        end
    end

    assign rdata  = data_q;
    assign rvalid = vld_q;
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int READ_CYC   = 2,
    parameter int WPULSE_CYC = 3,
    parameter int DSETUP_CYC = 2,
    parameter int TURN_CYC   = 2,
    parameter int RECOV_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC   = max_of(max_of(max_of(SETUP_CYC, READ_CYC),
                                             max_of(WPULSE_CYC, RECOV_CYC)), 1);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam int DRIVE_CYC = (DSETUP_CYC > WPULSE_CYC) ? WPULSE_CYC : DSETUP_CYC;
    localparam logic [CNT_W-1:0] DRIVE_L  = CNT_W'(DRIVE_CYC);
    localparam logic             DRIVE_AT_FALL = (WPULSE_CYC <= DRIVE_CYC);

    typedef struct packed {
        ctrl_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_last;
    logic             turn_ok;
    logic             cap_en;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .count    (tmr_cnt),
        .last     (tmr_last)
    );

    sram_turn_tracker #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (ctl_q.oe_n),
        .turn_ok (turn_ok)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (mem_dq_in),
        .rdata  (rsp_rdata),
        .rvalid (rsp_valid)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_en   = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.dq_oe = 1'b0;
                if (req_valid) begin
                    // address moves here, with every strobe still high
                    ctl_d.state = ST_SETUP;
                    ctl_d.addr  = req_addr;
                    ctl_d.wr    = req_write;
                    ctl_d.wdata = req_wdata;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(SETUP_CYC);
                end
            end

            ST_SETUP: begin
                if (tmr_last) begin
                    if (!ctl_q.wr) begin
                        ctl_d.state = ST_READ;
                        ctl_d.ce_n  = 1'b0;
                        ctl_d.oe_n  = 1'b0;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(READ_CYC);
                    end else if (turn_ok) begin
                        // select and strobe fall together; gate stays high
                        ctl_d.state = ST_WRITE;
                        ctl_d.ce_n  = 1'b0;
                        ctl_d.we_n  = 1'b0;
                        ctl_d.dq_oe = DRIVE_AT_FALL;
                        tmr_load    = 1'b1;
                        tmr_val     = CNT_W'(WPULSE_CYC);
                    end
                end
            end

            ST_READ: begin
                if (tmr_last) begin
                    cap_en      = 1'b1;
                    ctl_d.state = ST_RECOV;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(RECOV_CYC);
                end
            end

            ST_WRITE: begin
                if (tmr_last) begin
                    // driver kept on for one hold cycle after the strobe rises
                    ctl_d.state = ST_RECOV;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.we_n  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(RECOV_CYC);
                end else begin
                    // next cycle has tmr_cnt cycles of pulse remaining
                    ctl_d.dq_oe = ctl_q.dq_oe | (tmr_cnt <= DRIVE_L);
                end
            end

            ST_RECOV: begin
                ctl_d.dq_oe = 1'b0;
                if (tmr_last) begin
                    ctl_d.state = ST_IDLE;
                end
            end

            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.ce_n  = 1'b1;
                ctl_d.oe_n  = 1'b1;
                ctl_d.we_n  = 1'b1;
                ctl_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.addr  <= '0;
            ctl_q.wr    <= 1'b0;
            ctl_q.wdata <= '0;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.dq_oe <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = (ctl_q.state == ST_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_ce_n   = ctl_q.ce_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_dq_out = ctl_q.wdata;
    assign mem_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    // R1 and R7: ready only in the idle condition
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

    assert_addr_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $stable(mem_addr));

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    assert_select_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $fell(mem_ce_n));

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    assert_no_rsp_in_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !rsp_valid);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;
    localparam int S_C = 1, R_C = 2, W_C = 3, D_C = 2, T_C = 2, V_C = 1;
    localparam int RSP_LAT = S_C + R_C + 1;
    localparam int RD_DONE = S_C + R_C + V_C + 1;
    localparam int WR_DONE = S_C + W_C + V_C + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  rsp_rdata, mem_dq_out;
    logic [18:0] mem_addr;
    logic [7:0]  mdq_in = 8'hEE;

    int checks = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;

    sram_strobe_ctrl #(
        .SETUP_CYC(S_C), .READ_CYC(R_C), .WPULSE_CYC(W_C),
        .DSETUP_CYC(D_C), .TURN_CYC(T_C), .RECOV_CYC(V_C)
    ) u_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mdq_in)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- behavioural RAM model with protocol watch ----------
    logic [7:0] ram [int unsigned];
    logic p_ce_n = 1'b1, p_oe_n = 1'b1, p_we_n = 1'b1, p_dq_oe = 1'b0;
    logic [18:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int we_run = 0, drv_run = 0, rd_run = 0, oe_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int hi_now;
            hi_now = mem_oe_n ? oe_hi + 1 : 0;
            if (!mem_ce_n && !p_ce_n && mem_addr != p_addr)
                chk(0, "R2 address moved while selected", mem_addr, p_addr);
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R6 driver on with gate low", 1, 0);
            if (mem_dq_oe && !p_dq_oe && hi_now <= T_C)
                chk(0, "R6 turnaround too short", hi_now, T_C + 1);
            if (!mem_we_n && (mem_ce_n || !mem_oe_n))
                chk(0, "R4 strobe without select or with gate low", 0, 1);
            if (!mem_we_n && p_we_n && !p_ce_n)
                chk(0, "R4 select fell before strobe", 0, 1);
            if (!mem_we_n) begin
                we_run++;
                if (mem_dq_oe) drv_run++;
            end
            if (mem_we_n && !p_we_n) begin
                chk(we_run == W_C, "R4 strobe width", we_run, W_C);
                chk(drv_run >= D_C, "R5 data setup cycles", drv_run, D_C);
                chk(mem_dq_oe && mem_dq_out == p_dq, "R5 data hold after strobe", mem_dq_out, p_dq);
                ram[32'(p_addr)] = p_dq;
                we_run = 0;
                drv_run = 0;
            end
            if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_run++;
            if (mem_oe_n && !p_oe_n) begin
                chk(rd_run == R_C, "R3 read window width", rd_run, R_C);
                rd_run = 0;
            end
            mdq_in = (!mem_ce_n && !mem_oe_n && mem_we_n)
                   ? (ram.exists(32'(mem_addr)) ? ram[32'(mem_addr)] : 8'h5A) : 8'hEE;
            oe_hi = hi_now;
            p_ce_n = mem_ce_n; p_oe_n = mem_oe_n; p_we_n = mem_we_n;
            p_dq_oe = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
        end
    end

    // ---------------- request tasks ----------------
    task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit disturb);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (disturb) begin
            req_addr = ~a; req_wdata = ~d; req_write = 1'b0;  // R8
        end
        n = 1;
        chk(!req_ready, "R7 ready low after accept", req_ready, 0);
        while (!req_ready && n < 40) begin
            if (rsp_valid) chk(0, "R10 response on write", 1, 0);
            @(negedge clk);
            n++;
        end
        chk(n == WR_DONE, "R7 write occupancy", n, WR_DONE);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] exp, input string rq);
        int n, seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1; seen = 0;
        while (!req_ready && n < 40) begin
            if (rsp_valid) begin
                seen++;
                chk(n == RSP_LAT, "R3 response latency", n, RSP_LAT);
                chk(rsp_rdata == exp, rq, rsp_rdata, exp);
            end
            @(negedge clk);
            n++;
        end
        chk(seen == 1, "R3 one response per read", seen, 1);
        chk(n == RD_DONE, "R7 read occupancy", n, RD_DONE);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high after reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 idle outputs",
            {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
    endtask

    task automatic t_patterns();
        do_write(19'h00123, 8'hA5, 0);
        do_read(19'h00123, 8'hA5, "R3 read-back A5");
        do_write(19'h2BEEF, 8'h3C, 0);
        do_write(19'h2BEF0, 8'hC3, 0);
        do_read(19'h2BEEF, 8'h3C, "R4 neighbour intact 3C");
        do_read(19'h2BEF0, 8'hC3, "R4 read-back C3");
    endtask

    task automatic t_bounds();
        do_write(19'h00000, 8'h01, 0);
        do_write(19'h7FFFF, 8'hFE, 0);
        do_read(19'h00000, 8'h01, "R9 lowest location");
        do_read(19'h7FFFF, 8'hFE, "R9 highest location");
    endtask

    task automatic t_overwrite();
        do_write(19'h40000, 8'h11, 0);
        do_write(19'h40000, 8'h99, 0);
        do_read(19'h40000, 8'h99, "R4 latest write wins");
    endtask

    task automatic t_disturb();
        do_write(19'h15555, 8'h6B, 1);
        chk(!ram.exists(32'(~19'h15555)), "R8 disturbed address untouched", 0, 0);
        do_read(19'h15555, 8'h6B, "R8 write used accepted values");
    endtask

    task automatic t_rw_alternate();
        for (int i = 0; i < 4; i++) begin
            do_write(19'(i * 19'h1111), 8'(8'h20 + i), 0);
            do_read(19'(i * 19'h1111), 8'(8'h20 + i), "R6 alternating read/write");
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_patterns();
        t_bounds();
        t_overwrite();
        t_disturb();
        t_rw_alternate();
        t_reset();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule